// File: doc/BRIEF.md
# Byte-Lane SIMD Integer Multiplier

This block multiplies two W-bit operands that can be cut into independent lanes along byte boundaries. One enable bit sits on each internal byte boundary. A lane is any run of bytes with no enabled boundary inside it, so a 32-bit datapath can carry one 32-bit product, two 16-bit products, four 8-bit products, or any mix of these. Each lane reads its own 2-bit operation code, which selects the low half of the lane product or one of three signed/unsigned forms of the high half. The selected half is written back into the bit range the lane occupies in the operands.

A single multiplier array serves every lane layout. For each bit of b, one partial product is formed from the bytes of a that lie in the same lane. Four more terms apply the sign correction that a lane needs when it is signed. A carry-save tree of 3:2 compressors then reduces all these terms to two. In that tree, each carry vector is shifted up by one bit and masked, so that no carry crosses into product bit 16k when boundary k is enabled. A final adder then adds the two remaining terms in one wide add. It inserts a guard bit at each boundary, so a carry ripples across an open boundary and stops at a closed one.

A bit mask parameter can place a register after any reduction level. The boundary enables and the operation codes travel through these registers together with the data.

Top module: `pmul_simd`

## Requirements
- R1: `seg_en_i[k]` closes the boundary between byte k and byte k+1 (bit 8k+8). The top of the operand is always a boundary. A lane is a maximal run of bytes with no closed boundary inside it, and each lane's result depends only on its own bytes of a and b, for all 2^(NB-1) values of `seg_en_i`.
- R2: A lane takes its operation code from `lane_op_i[2j+1:2j]`, where j is the lane's least significant byte. The codes of the lane's other bytes have no effect.
- R3: Code 00 yields the low n bits of the lane product, where n is the lane width. Multiplying by 1 in every byte lane returns a unchanged.
- R4: Code 01 yields the high n bits of the product with both lane operands signed.
- R5: Code 10 yields the high n bits of the product with the a lane signed and the b lane unsigned.
- R6: Code 11 yields the high n bits of the product with both lane operands unsigned.
- R7: Each lane's n-bit result appears in `res_o` at the same bit positions the lane holds in the operands. This also holds for a single lane spanning the full width.
- R8: Setting bit l of `PIPE_LVLS` inserts a register after reduction level l. The latency equals the number of such bits that fall on existing levels, and once inputs are held for that many cycles the output no longer changes. Operations issued on consecutive cycles with different lane layouts and codes each come out correct.
- R9: With at least one register inserted, `res_o` reads zero while `rst_ni` is low.
- R10: An all-zero a gives an all-zero `res_o` for every layout and code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional reduction-level registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_i | input | W | Multiplicand, byte lanes |
| b_i | input | W | Multiplier, byte lanes |
| seg_en_i | input | NB-1 | Boundary enables; bit k closes the boundary above byte k |
| lane_op_i | input | 2*NB | Operation code per byte, bits 2k+1:2k for byte k |
| res_o | output | W | Selected half of each lane product, in the lane's own bits |

## Verification
The bench builds the block with W=32 (four bytes, 36 reduction terms, eight reduction levels) and PIPE_LVLS=16'h0012, which places registers after levels 1 and 4 for a latency of two cycles. With registers present, the reset state of the output can be observed. Back-to-back issue then shows that the boundary enables and codes stay aligned with their data across two register stages, with unregistered levels between and after them. The four-byte width covers all eight boundary layouts, including uneven lanes such as 8+16+8, along with every code in 8-, 16-, 24- and 32-bit lanes.

// File: rtl/pmul_pkg.sv
package pmul_pkg;

  function automatic int next_terms(int n);
    return 2 * (n / 3) + n % 3;
  endfunction

  function automatic int terms_after(int n0, int lvl);
    int n;
    n = n0;
    for (int i = 0; i < lvl; i++) n = next_terms(n);
    return n;
  endfunction

  function automatic int num_levels(int n0);
    int n;
    int c;
    n = n0;
    c = 0;
    while (n > 2) begin
      n = next_terms(n);
      c++;
    end
    return c;
  endfunction

  function automatic int stage_count(logic [15:0] m, int nl);
    int c;
    c = 0;
    for (int i = 0; i < 16; i++) if (i < nl && m[i]) c++;
    return c;
  endfunction

endpackage

// File: rtl/pmul_lane_dec.sv
module pmul_lane_dec #(
  parameter int NB = 4,
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-2:0]           seg_en_i,
  input  logic [2*NB-1:0]         lane_op_i,
  output logic [NB-1:0][BIW-1:0]  lo_o,
  output logic [NB-1:0][BIW-1:0]  hi_o,
  output logic [NB-1:0][1:0]      lop_o
);

  always_comb begin
    int   lo_v;
    int   hi_v;
    logic stp;
    for (int k = 0; k < NB; k++) begin
      // scan down to the nearest closed boundary below byte k
      lo_v = k;
      stp  = 1'b0;
      for (int j = NB - 2; j >= 0; j--) begin
        if (j < k && !stp) begin
          if (seg_en_i[j]) stp = 1'b1;
          else             lo_v = j;
        end
      end
      // scan up to the nearest closed boundary above byte k
      hi_v = k;
      stp  = 1'b0;
      for (int j = 0; j < NB - 1; j++) begin
        if (j >= k && !stp) begin
          if (seg_en_i[j]) stp = 1'b1;
          else             hi_v = j + 1;
        end
      end
      lo_o[k]  = BIW'(lo_v);
      hi_o[k]  = BIW'(hi_v);
      lop_o[k] = lane_op_i[2*lo_v +: 2];
    end
  end

endmodule

// File: rtl/pmul_pp_gen.sv
module pmul_pp_gen #(
  parameter int W  = 32,
  parameter int NB = W / 8,
  localparam int PW  = 2 * W,
  localparam int NT  = W + 4,
  localparam int BIW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [W-1:0]            a_i,
  input  logic [W-1:0]            b_i,
  input  logic [NB-1:0][BIW-1:0]  lo_i,
  input  logic [NB-1:0][BIW-1:0]  hi_i,
  input  logic [NB-1:0][1:0]      lop_i,
  output logic [NT-1:0][PW-1:0]   terms_o
);

  always_comb begin
    logic [W-1:0] am;
    int   kj;
    int   base;
    int   n;
    int   rel;
    logic act_a;
    logic act_b;
    logic vb;
    logic va;
    terms_o = '0;
    // one term per bit of b: a restricted to that bit's lane
    for (int j = 0; j < W; j++) begin
      kj = j / 8;
      am = '0;
      for (int i = 0; i < W; i++)
        if (i / 8 >= int'(lo_i[kj]) && i / 8 <= int'(hi_i[kj])) am[i] = a_i[i];
      if (b_i[j]) terms_o[j] = PW'(am) << j;
    end
    // sign correction: subtract (msb ? other_operand << n : 0) inside each lane field
    for (int i = 0; i < PW; i++) begin
      kj    = i / 16;
      base  = 8 * int'(lo_i[kj]);
      n     = 8 * (int'(hi_i[kj]) - int'(lo_i[kj]) + 1);
      rel   = i - 2 * base;
      act_a = (lop_i[kj] == 2'b01 || lop_i[kj] == 2'b10) && a_i[base+n-1];
      act_b = (lop_i[kj] == 2'b01) && b_i[base+n-1];
      vb = 1'b0;
      va = 1'b0;
      if (rel >= n) begin
        vb = b_i[base+rel-n];
        va = a_i[base+rel-n];
      end
      terms_o[W][i]   = act_a & ~vb;
      terms_o[W+1][i] = act_b & ~va;
      terms_o[W+2][i] = act_a & (rel == 0);
      terms_o[W+3][i] = act_b & (rel == 0);
    end
  end

endmodule

// File: rtl/pmul_csa_lvl.sv
module pmul_csa_lvl #(
  parameter int PW   = 64,
  parameter int NB   = 4,
  parameter int N_IN = 36,
  localparam int G     = N_IN / 3,
  localparam int R     = N_IN % 3,
  localparam int N_OUT = 2 * G + R
) (
  input  logic [N_IN-1:0][PW-1:0]  terms_i,
  input  logic [NB-2:0]            seg_en_i,
  output logic [N_OUT-1:0][PW-1:0] terms_o
);

  logic [PW-1:0] cmask;

  always_comb begin
    cmask = '1;
    for (int k = 1; k < NB; k++)
      if (seg_en_i[k-1]) cmask[16*k] = 1'b0;
  end

  for (genvar g = 0; g < G; g++) begin : g_fa
    logic [PW-1:0] x, y, z;
    assign x = terms_i[3*g];
    assign y = terms_i[3*g+1];
    assign z = terms_i[3*g+2];
    assign terms_o[2*g]   = x ^ y ^ z;
    assign terms_o[2*g+1] = (((x & y) | (y & z) | (x & z)) << 1) & cmask;
  end

  for (genvar r = 0; r < R; r++) begin : g_pass
    assign terms_o[2*G+r] = terms_i[3*G+r];
  end

endmodule

// File: rtl/pmul_fin_add.sv
module pmul_fin_add #(
  parameter int W  = 32,
  parameter int NB = W / 8,
  localparam int PW = 2 * W,
  localparam int EW = PW + NB - 1
) (
  input  logic [PW-1:0]  x_i,
  input  logic [PW-1:0]  y_i,
  input  logic [NB-2:0]  seg_en_i,
  output logic [PW-1:0]  sum_o
);

  logic [EW-1:0] ea, eb, es;

  always_comb begin
    int idx;
    ea  = '0;
    eb  = '0;
    idx = 0;
    for (int i = 0; i < PW; i++) begin
      if (i > 0 && i % 16 == 0) begin
        ea[idx] = ~seg_en_i[i/16-1];  // 1 lets a carry ripple through
        idx++;
      end
      ea[idx] = x_i[i];
      eb[idx] = y_i[i];
      idx++;
    end
  end

  assign es = ea + eb;

  always_comb begin
    int idx;
    idx = 0;
    for (int i = 0; i < PW; i++) begin
      if (i > 0 && i % 16 == 0) idx++;
      sum_o[i] = es[idx];
      idx++;
    end
  end

endmodule

// File: rtl/pmul_simd.sv
module pmul_simd #(
  parameter int          W         = 32,
  parameter logic [15:0] PIPE_LVLS = 16'h0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic [W/8-2:0]    seg_en_i,
  input  logic [W/4-1:0]    lane_op_i,
  output logic [W-1:0]      res_o
);
  import pmul_pkg::*;

  localparam int NB   = W / 8;
  localparam int PW   = 2 * W;
  localparam int NT   = W + 4;
  localparam int BIW  = (NB > 1) ? $clog2(NB) : 1;
  localparam int NLVL = num_levels(NT);
  localparam int LAT  = stage_count(PIPE_LVLS, NLVL);

  logic [NB-1:0][BIW-1:0] lo_in, hi_in, lo_out, hi_out;
  logic [NB-1:0][1:0]     lop_in, lop_out;
  logic [NT-1:0][PW-1:0]  pp_terms;
  logic [PW-1:0]          fin_x, fin_y, fin_sum;
  logic [NB-2:0]          fin_pen;
  logic [2*NB-1:0]        fin_op;

  pmul_lane_dec #(.NB(NB)) u_dec_in (
    .seg_en_i (seg_en_i),
    .lane_op_i(lane_op_i),
    .lo_o     (lo_in),
    .hi_o     (hi_in),
    .lop_o    (lop_in)
  );

  pmul_pp_gen #(.W(W), .NB(NB)) u_pp (
    .a_i    (a_i),
    .b_i    (b_i),
    .lo_i   (lo_in),
    .hi_i   (hi_in),
    .lop_i  (lop_in),
    .terms_o(pp_terms)
  );

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    localparam int NI = terms_after(NT, l);
    localparam int NO = terms_after(NT, l + 1);
    logic [NI-1:0][PW-1:0] t_in;
    logic [NO-1:0][PW-1:0] t_cmb, t_out;
    logic [NB-2:0]         pen_in, pen_out;
    logic [2*NB-1:0]       op_in, op_out;

    if (l == 0) begin : g_src
      assign t_in   = pp_terms;
      assign pen_in = seg_en_i;
      assign op_in  = lane_op_i;
    end else begin : g_chain
      assign t_in   = g_lvl[l-1].t_out;
      assign pen_in = g_lvl[l-1].pen_out;
      assign op_in  = g_lvl[l-1].op_out;
    end

    pmul_csa_lvl #(.PW(PW), .NB(NB), .N_IN(NI)) u_csa (
      .terms_i (t_in),
      .seg_en_i(pen_in),
      .terms_o (t_cmb)
    );

    if (PIPE_LVLS[l]) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          t_out   <= '0;
          pen_out <= '0;
          op_out  <= '0;
        end else begin
          t_out   <= t_cmb;
          pen_out <= pen_in;
          op_out  <= op_in;
        end
      end
    end else begin : g_thru
      assign t_out   = t_cmb;
      assign pen_out = pen_in;
      assign op_out  = op_in;
    end
  end

  assign fin_x   = g_lvl[NLVL-1].t_out[0];
  assign fin_y   = g_lvl[NLVL-1].t_out[1];
  assign fin_pen = g_lvl[NLVL-1].pen_out;
  assign fin_op  = g_lvl[NLVL-1].op_out;

  pmul_fin_add #(.W(W), .NB(NB)) u_fin (
    .x_i     (fin_x),
    .y_i     (fin_y),
    .seg_en_i(fin_pen),
    .sum_o   (fin_sum)
  );

  pmul_lane_dec #(.NB(NB)) u_dec_out (
    .seg_en_i (fin_pen),
    .lane_op_i(fin_op),
    .lo_o     (lo_out),
    .hi_o     (hi_out),
    .lop_o    (lop_out)
  );

  // pick the selected half of each lane's 2n-bit field
  always_comb begin
    int k;
    int base;
    int n;
    int src;
    for (int i = 0; i < W; i++) begin
      k    = i / 8;
      base = 8 * int'(lo_out[k]);
      n    = 8 * (int'(hi_out[k]) - int'(lo_out[k]) + 1);
      src  = 2 * base + (i - base) + ((lop_out[k] != 2'b00) ? n : 0);
      res_o[i] = fin_sum[src];
    end
  end

endmodule

// File: rtl/pmul_simd_chk.sv
module pmul_simd_chk #(
  parameter int W   = 32,
  parameter int NB  = 4,
  parameter int LAT = 0,
  localparam int PW   = 2 * W,
  localparam int CNTW = $clog2(LAT + 2) + 1
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [W-1:0]    a_i,
  input logic [W-1:0]    b_i,
  input logic [NB-2:0]   seg_en_i,
  input logic [2*NB-1:0] lane_op_i,
  input logic [W-1:0]    res_o,
  input logic [PW-1:0]   fin_x_i,
  input logic [PW-1:0]   fin_y_i,
  input logic [NB-2:0]   fin_pen_i,
  input logic [PW-1:0]   fin_sum_i
);

  logic [W-1:0]    a_q, b_q;
  logic [NB-2:0]   pen_q;
  logic [2*NB-1:0] op_q;
  logic            vld_q;
  logic [CNTW-1:0] cnt_q;
  logic            same_now, settled;

  assign same_now = vld_q && a_i == a_q && b_i == b_q &&
                    seg_en_i == pen_q && lane_op_i == op_q;
  assign settled  = same_now && (int'(cnt_q) >= LAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0; b_q <= '0; pen_q <= '0; op_q <= '0;
      vld_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      a_q <= a_i; b_q <= b_i; pen_q <= seg_en_i; op_q <= lane_op_i;
      vld_q <= 1'b1;
      if (!same_now)                cnt_q <= '0;
      else if (int'(cnt_q) < LAT)   cnt_q <= cnt_q + 1'b1;
    end
  end

  p_settled_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    settled |-> $stable(res_o));

  p_zero_operand_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && a_i == '0) |-> res_o == '0);

  p_unit_mult_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (settled && (&seg_en_i) && lane_op_i == '0 && b_i == {NB{8'h01}}) |-> res_o == a_i);

  p_open_carry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_pen_i == '0) |-> fin_sum_i == fin_x_i + fin_y_i);

endmodule

bind pmul_simd pmul_simd_chk #(.W(W), .NB(NB), .LAT(LAT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .a_i      (a_i),
  .b_i      (b_i),
  .seg_en_i (seg_en_i),
  .lane_op_i(lane_op_i),
  .res_o    (res_o),
  .fin_x_i  (fin_x),
  .fin_y_i  (fin_y),
  .fin_pen_i(fin_pen),
  .fin_sum_i(fin_sum)
);

// File: tb/pmul_simd_bench.sv
module pmul_simd_bench;
  localparam int          W    = 32;
  localparam int          NB   = W / 8;
  localparam logic [15:0] PIPE = 16'h0012;  // registers after levels 1 and 4
  localparam int          LAT  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [W-1:0]    a = '0, b = '0;
  logic [NB-2:0]   pen = '0;
  logic [2*NB-1:0] op = '0;
  logic [W-1:0]    res;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmul_simd #(.W(W), .PIPE_LVLS(PIPE)) u_pmul_simd (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b),
    .seg_en_i(pen), .lane_op_i(op), .res_o(res)
  );

  function automatic logic [W-1:0] ref_res(logic [W-1:0] ra, logic [W-1:0] rb,
                                           logic [NB-2:0] rp, logic [2*NB-1:0] ro);
    logic [W-1:0]  r;
    logic [63:0]   m, pu, f;
    logic [1:0]    o;
    longint        av, bv, p;
    int            lo, hi, n, base;
    r  = '0;
    lo = 0;
    while (lo < NB) begin
      hi = lo;
      while (hi < NB - 1 && !rp[hi]) hi++;
      n    = 8 * (hi - lo + 1);
      base = 8 * lo;
      o    = ro[2*lo +: 2];
      m    = (64'd1 << n) - 64'd1;
      av   = longint'((64'(ra) >> base) & m);
      bv   = longint'((64'(rb) >> base) & m);
      if ((o == 2'b01 || o == 2'b10) && av[n-1]) av = av - longint'(64'd1 << n);
      if (o == 2'b01 && bv[n-1]) bv = bv - longint'(64'd1 << n);
      p  = av * bv;
      pu = 64'(p);
      f  = (o == 2'b00) ? pu : (pu >> n);
      for (int i = 0; i < n; i++) r[base+i] = f[i];
      lo = hi + 1;
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [W-1:0] exp);
    n_chk++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (a=%h b=%h seg=%b op=%b)",
               tag, res, exp, a, b, pen, op);
    end
  endtask

  task automatic apply(logic [W-1:0] ta, logic [W-1:0] tb,
                       logic [NB-2:0] tp, logic [2*NB-1:0] to);
    @(negedge clk);
    a = ta; b = tb; pen = tp; op = to;
    repeat (LAT) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;  // R9
    @(negedge clk);
    a = 32'hDEADBEEF; b = 32'h12345679; pen = '0; op = 8'hFF;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9", '0);
    rst_n = 1'b1;
  endtask

  task automatic t_ops;  // R3..R6 in byte lanes
    logic [W-1:0] va [4];
    logic [W-1:0] vb [4];
    string tg;
    va[0] = 32'h80FF7F01; vb[0] = 32'h80FF8002;
    va[1] = 32'hFFFFFFFF; vb[1] = 32'hFFFFFFFF;
    va[2] = $urandom;     vb[2] = $urandom;
    va[3] = $urandom;     vb[3] = $urandom;
    for (int o = 0; o < 4; o++) begin
      tg = (o == 0) ? "R3" : (o == 1) ? "R4" : (o == 2) ? "R5" : "R6";
      for (int v = 0; v < 4; v++) begin
        apply(va[v], vb[v], 3'b111, {4{2'(o)}});
        chk(tg, ref_res(va[v], vb[v], 3'b111, {4{2'(o)}}));
      end
    end
    apply(32'hA55A3C7E, {NB{8'h01}}, 3'b111, '0);
    chk("R3", 32'hA55A3C7E);
  endtask

  task automatic t_wide;  // R7: one lane over the full width
    logic [W-1:0] ta, tb;
    for (int o = 0; o < 4; o++) begin
      apply(32'h80000000, 32'h80000000, 3'b000, {4{2'(o)}});
      chk("R7", ref_res(32'h80000000, 32'h80000000, 3'b000, {4{2'(o)}}));
      ta = $urandom; tb = $urandom;
      apply(ta, tb, 3'b000, {4{2'(o)}});
      chk("R7", ref_res(ta, tb, 3'b000, {4{2'(o)}}));
    end
  endtask

  task automatic t_layouts;  // R1 over every boundary layout
    logic [W-1:0] ta, tb;
    logic [2*NB-1:0] to;
    for (int p = 0; p < 8; p++) begin
      for (int v = 0; v < 4; v++) begin
        ta = $urandom; tb = $urandom; to = 8'($urandom);
        apply(ta, tb, 3'(p), to);
        chk("R1", ref_res(ta, tb, 3'(p), to));
      end
    end
    // one saturated lane beside zero lanes
    apply(32'h00FF0000, 32'h00FF0000, 3'b111, 8'hFF);
    chk("R1", 32'h00FE0000);
  endtask

  task automatic t_op_source;  // R2: upper-byte codes of a lane are ignored
    // lanes: byte0 | bytes1-2 | byte3; lane 1-2 takes its code from byte1 (11)
    apply(32'hF08193A7, 32'h9C7FE205, 3'b101, 8'b10_01_11_00);
    chk("R2", ref_res(32'hF08193A7, 32'h9C7FE205, 3'b101, 8'b10_11_11_00));
    apply(32'hF08193A7, 32'h9C7FE205, 3'b101, 8'b10_00_11_00);
    chk("R2", ref_res(32'hF08193A7, 32'h9C7FE205, 3'b101, 8'b10_11_11_00));
  endtask

  task automatic t_zero;  // R10
    logic [W-1:0] tb;
    for (int p = 0; p < 8; p += 3) begin
      tb = $urandom;
      apply('0, tb, 3'(p), 8'($urandom));
      chk("R10", '0);
    end
  endtask

  task automatic t_stream;  // R8: new operation every cycle
    logic [W-1:0]    sa [16];
    logic [W-1:0]    sb [16];
    logic [NB-2:0]   sp [16];
    logic [2*NB-1:0] so [16];
    for (int i = 0; i < 16; i++) begin
      sa[i] = $urandom; sb[i] = $urandom; sp[i] = 3'($urandom); so[i] = 8'($urandom);
    end
    for (int c = 0; c < 16 + LAT; c++) begin
      @(negedge clk);
      if (c >= LAT) chk("R8", ref_res(sa[c-LAT], sb[c-LAT], sp[c-LAT], so[c-LAT]));
      if (c < 16) begin
        a = sa[c]; b = sb[c]; pen = sp[c]; op = so[c];
      end
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    t_reset();
    t_ops();
    t_wide();
    t_layouts();
    t_op_source();
    t_zero();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule